// File: doc/BRIEF.md
# Two-Channel Fixed-Point Gain Correction

This block rescales two independent streams of 16-bit signed samples, typically the outputs of a decimating filter chain whose residual gain sits slightly above one (roughly 1.05 to 1.26, depending on the rate chosen). Each channel has its own 16-bit signed coefficient and its own runtime enable. When a channel is enabled, its sample is multiplied by the coefficient, rounded and saturated back to 16 bits. When it is disabled, the sample is forwarded untouched.

The coefficient uses a signed 1.1.14 layout: one sign bit, one integer bit and fourteen fraction bits. So 0x4000 is unity and gains just below 2 can be reached. A build-time parameter decides whether the multiplier exists at all. By default it does not, and the block is then a plain two-cycle delay. The corrected and forwarded paths have identical latency, so downstream timing does not depend on the enable setting.

Top module: `scale_corr`

## Requirements
- R1: While `rst_ni` is low, both output valids are 0 and both output data buses are 0. The captured enable and product state also clear to zero.
- R2: `corr_en_i` bit 0 enables correction on channel A only, and bit 1 enables it on channel B only. Each bit affects its own channel and no other.
- R3: For an enabled channel, the output is floor((data × coef + 8192) / 16384). This is the 32-bit product shifted right arithmetically by 14 and rounded to nearest, with ties going toward +infinity. Data and coefficient are both read as two's-complement.
- R4: The coefficient is signed 1.1.14, so 0x4000 means 1.0 and an enabled channel with coefficient 0x4000 outputs its input unchanged.
- R5: A corrected result above 32767 gives 32767, and one below -32768 gives -32768. The result never wraps, so the sign of a non-zero output matches the sign of the product.
- R6: A channel whose enable bit is 0 outputs its input sample bit-for-bit.
- R7: Each output valid is its input valid delayed by exactly 2 clock cycles, and the matching data appears with it. When the output valid is low, the output data holds the last value delivered.
- R8: The coefficient and enable are sampled in the same cycle as the sample whose valid is high. Changes in later cycles do not alter a sample already in flight.
- R9: When the build parameter `CORR_EN` is 0, both channels forward their input unchanged whatever `corr_en_i` and the coefficients are, with the same 2-cycle latency.
- R10: The two channels run independently. Either valid may be high in any cycle without affecting the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_valid_i | input | 1 | Channel A sample strobe |
| a_data_i | input | 16 | Channel A sample, two's-complement |
| b_valid_i | input | 1 | Channel B sample strobe |
| b_data_i | input | 16 | Channel B sample, two's-complement |
| a_coef_i | input | 16 | Channel A gain, signed 1.1.14 |
| b_coef_i | input | 16 | Channel B gain, signed 1.1.14 |
| corr_en_i | input | 2 | Bit 0 enables channel A correction, bit 1 enables channel B |
| a_valid_o | output | 1 | Channel A result strobe |
| a_data_o | output | 16 | Channel A result |
| b_valid_o | output | 1 | Channel B result strobe |
| b_data_o | output | 16 | Channel B result |

## Verification
The properties assume that data, coefficient and enable are known (not X) in every cycle after reset where that channel's valid is high. They also assume the input valids are held low for the whole reset. The bench drives every input at the falling edge, holds the valids low during reset, and always gives data, coefficient and enable defined values. It covers full-scale corners, including -32768 times -32768 and 32767 times 0x7FFF, as well as rounding ties of both signs and coefficients that change on the cycle right after a captured sample.

// File: rtl/scale_corr_pkg.sv
package scale_corr_pkg;
  localparam int NUM_LANES = 2;
  typedef enum logic [0:0] {
    LANE_A = 1'b0,
    LANE_B = 1'b1
  } lane_e;
endpackage

// File: rtl/scale_corr_mul.sv
// Stage 1: capture sample, enable and full-precision product on valid.
module scale_corr_mul #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic [COEF_W-1:0]        coef_i,
  input  logic                     en_i,
  output logic                     valid_o,
  output logic                     en_o,
  output logic [DATA_W-1:0]        data_o,
  output logic signed [PROD_W-1:0] prod_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      en_o    <= 1'b0;
      data_o  <= '0;
      prod_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        en_o   <= en_i;
        data_o <= data_i;
        prod_o <= $signed(data_i) * $signed(coef_i);
      end
    end
  end
endmodule

// File: rtl/scale_corr_rsat.sv
// Stage 2: round-to-nearest, arithmetic shift, saturate, select, register.
module scale_corr_rsat #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int SUM_W  = PROD_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     en_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic                     valid_o,
  output logic [DATA_W-1:0]        data_o
);
  localparam logic signed [SUM_W-1:0] RND_V =
    {{(SUM_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [SUM_W-1:0] MAX_V =
    {{(SUM_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] MIN_V =
    {{(SUM_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum_w, shr_w;
  logic [DATA_W-1:0]       sat_w, sel_w;

  always_comb begin
    sum_w = $signed({prod_i[PROD_W-1], prod_i}) + RND_V;
    shr_w = sum_w >>> FRAC_W;
    if (shr_w > MAX_V)      sat_w = MAX_V[DATA_W-1:0];
    else if (shr_w < MIN_V) sat_w = MIN_V[DATA_W-1:0];
    else                    sat_w = shr_w[DATA_W-1:0];
    sel_w = en_i ? sat_w : data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sel_w;
    end
  end

  // R5: non-negative product never yields a negative result, and vice versa
  assert_no_wrap_pos_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && en_i && !prod_i[PROD_W-1]) |=> !data_o[DATA_W-1]);
  assert_no_wrap_neg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && en_i && prod_i[PROD_W-1]) |=> (data_o[DATA_W-1] || data_o == '0));
endmodule

// File: rtl/scale_corr_lane.sv
module scale_corr_lane #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 14,
  parameter bit CORR_EN = 1'b0,
  localparam int PROD_W = DATA_W + COEF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic              en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << FRAC_W;

  if (CORR_EN) begin : g_corr
    logic                     s1_valid, s1_en;
    logic [DATA_W-1:0]        s1_data;
    logic signed [PROD_W-1:0] s1_prod;

    scale_corr_mul #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
      .clk_i, .rst_ni, .valid_i, .data_i, .coef_i, .en_i,
      .valid_o(s1_valid), .en_o(s1_en), .data_o(s1_data), .prod_o(s1_prod)
    );

    scale_corr_rsat #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_rsat (
      .clk_i, .rst_ni, .valid_i(s1_valid), .en_i(s1_en), .data_i(s1_data),
      .prod_i(s1_prod), .valid_o, .data_o
    );

    assert_bypass_exact_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && $past(!en_i, 2)) |-> data_o == $past(data_i, 2));
    assert_unity_gain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && $past(en_i && coef_i == UNITY, 2)) |-> data_o == $past(data_i, 2));
  end else begin : g_bypass
    logic              s1_valid;
    logic [DATA_W-1:0] s1_data;
    logic              unused_cfg;
    assign unused_cfg = ^{coef_i, en_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_valid <= 1'b0;
        s1_data  <= '0;
        valid_o  <= 1'b0;
        data_o   <= '0;
      end else begin
        s1_valid <= valid_i;
        valid_o  <= s1_valid;
        if (valid_i)  s1_data <= data_i;
        if (s1_valid) data_o  <= s1_data;
      end
    end

    assert_build_off_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> data_o == $past(data_i, 2));
  end

  assert_valid_origin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 2));
  assert_valid_arrives_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i, 2) && $past(rst_ni, 2) && $past(rst_ni)) |-> valid_o);
  assert_hold_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !valid_o) |-> $stable(data_o));
endmodule

// File: rtl/scale_corr.sv
module scale_corr #(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC_W  = 14,
  parameter bit CORR_EN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_valid_i,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              b_valid_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic [COEF_W-1:0] a_coef_i,
  input  logic [COEF_W-1:0] b_coef_i,
  input  logic [1:0]        corr_en_i,
  output logic              a_valid_o,
  output logic [DATA_W-1:0] a_data_o,
  output logic              b_valid_o,
  output logic [DATA_W-1:0] b_data_o
);
  import scale_corr_pkg::*;

  logic [NUM_LANES-1:0]             vin, vout;
  logic [NUM_LANES-1:0][DATA_W-1:0] din, dout;
  logic [NUM_LANES-1:0][COEF_W-1:0] cin;

  assign vin[LANE_A] = a_valid_i;
  assign vin[LANE_B] = b_valid_i;
  assign din[LANE_A] = a_data_i;
  assign din[LANE_B] = b_data_i;
  assign cin[LANE_A] = a_coef_i;
  assign cin[LANE_B] = b_coef_i;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    scale_corr_lane #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .CORR_EN(CORR_EN)
    ) u_lane (
      .clk_i, .rst_ni,
      .valid_i(vin[i]), .data_i(din[i]), .coef_i(cin[i]), .en_i(corr_en_i[i]),
      .valid_o(vout[i]), .data_o(dout[i])
    );
  end

  assign a_valid_o = vout[LANE_A];
  assign b_valid_o = vout[LANE_B];
  assign a_data_o  = dout[LANE_A];
  assign b_data_o  = dout[LANE_B];

  // R10: one channel's strobe never produces the other's output strobe
  assert_lane_independent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_o && !b_valid_o) |-> ($past(a_valid_i, 2) && !$past(b_valid_i, 2)));
endmodule

// File: tb/scale_corr_tb.sv
module scale_corr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        va = 1'b0, vb = 1'b0;
  logic [15:0] da = '0, db = '0, ca = '0, cb = '0;
  logic [1:0]  ctrl = '0;
  logic        ova, ovb, pva, pvb;
  logic [15:0] oda, odb, pda, pdb;

  int total = 0, bad = 0;
  bit done = 1'b0;

  int    q_val [4][$];
  bit    q_vld [4][$];
  string q_tag [4][$];
  int    last  [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  scale_corr #(.CORR_EN(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_valid_i(va), .a_data_i(da), .b_valid_i(vb),
    .b_data_i(db), .a_coef_i(ca), .b_coef_i(cb), .corr_en_i(ctrl),
    .a_valid_o(ova), .a_data_o(oda), .b_valid_o(ovb), .b_data_o(odb));

  scale_corr #(.CORR_EN(1'b0)) u_dut_off (
    .clk_i(clk), .rst_ni(rst_n), .a_valid_i(va), .a_data_i(da), .b_valid_i(vb),
    .b_data_i(db), .a_coef_i(ca), .b_coef_i(cb), .corr_en_i(ctrl),
    .a_valid_o(pva), .a_data_o(pda), .b_valid_o(pvb), .b_data_o(pdb));

  function automatic int ref_gain(int d, int c, bit en, output bit sat);
    longint p, r;
    sat = 1'b0;
    if (!en) return d;
    p = longint'(d) * longint'(c);
    r = (p + 64'sd8192) >>> 14;
    if (r > 32767)  begin sat = 1'b1; return 32767;  end
    if (r < -32768) begin sat = 1'b1; return -32768; end
    return int'(r);
  endfunction

  function automatic bit out_v(int s);
    case (s) 0: return ova; 1: return ovb; 2: return pva; default: return pvb; endcase
  endfunction
  function automatic int out_d(int s);
    logic [15:0] x;
    case (s) 0: x = oda; 1: x = odb; 2: x = pda; default: x = pdb; endcase
    return int'($signed(x));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < 4; s++) begin
      q_val[s].delete(); q_vld[s].delete(); q_tag[s].delete(); last[s] = 0;
    end
  endtask

  // one clock: compare results due now, then drive next inputs and predict
  task automatic step(bit iva, int ida, bit ivb, int idb, int ica, int icb,
                      logic [1:0] ictrl, string tag);
    bit sat; int e; bit v; string t;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      if (q_vld[s].size() == 2) begin
        v = q_vld[s].pop_front(); e = q_val[s].pop_front(); t = q_tag[s].pop_front();
        if (v) last[s] = e;
        chk(out_v(s) == v, "R7", $sformatf("valid stream %0d", s), out_v(s), v);
        chk(out_d(s) == last[s], v ? t : "R7", $sformatf("data stream %0d", s),
            out_d(s), last[s]);
      end
    end
    va = iva; da = 16'(ida); vb = ivb; db = 16'(idb);
    ca = 16'(ica); cb = 16'(icb); ctrl = ictrl;
    for (int s = 0; s < 4; s++) begin
      int d, c; bit en, vv;
      d  = (s % 2 == 0) ? int'($signed(da)) : int'($signed(db));
      c  = (s % 2 == 0) ? int'($signed(ca)) : int'($signed(cb));
      en = (s < 2) ? ctrl[s] : 1'b0;
      vv = (s % 2 == 0) ? iva : ivb;
      e  = ref_gain(d, c, en, sat);
      if (s >= 2)           t = "R9";
      else if (tag != "")   t = tag;
      else if (!en)         t = "R6";
      else if (sat)         t = "R5";
      else if (c == 16384)  t = "R4";
      else                  t = "R3";
      q_vld[s].push_back(vv); q_val[s].push_back(e); q_tag[s].push_back(t);
    end
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535));
  endfunction

  task automatic check_reset_outputs();
    for (int s = 0; s < 4; s++) begin
      chk(out_v(s) == 1'b0, "R1", $sformatf("reset valid stream %0d", s), out_v(s), 0);
      chk(out_d(s) == 0, "R1", $sformatf("reset data stream %0d", s), out_d(s), 0);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    check_reset_outputs();                                   // R1
    rst_n = 1'b1;

    // R6: both disabled, data unchanged whatever coefficient
    for (int i = 0; i < 60; i++)
      step($urandom_range(0,1), rnd16(), $urandom_range(0,1), rnd16(), rnd16(), rnd16(), 2'b00, "");

    // R4: unity coefficient
    for (int i = 0; i < 40; i++)
      step(1'b1, rnd16(), 1'b1, rnd16(), 16'h4000, 16'h4000, 2'b11, "");

    // R3: rounding ties and typical correction gains
    step(1'b1, 1, 1'b1, -1, 16'h2000, 16'h2000, 2'b11, "R3");
    step(1'b1, 3, 1'b1, -3, 16'h2000, 16'h2000, 2'b11, "R3");
    step(1'b1, 1000, 1'b1, -1000, 16'h4333, 16'h50a4, 2'b11, "R3");
    for (int i = 0; i < 80; i++)
      step($urandom_range(0,1), int'($urandom_range(0,8191)) - 4096, $urandom_range(0,1),
           int'($urandom_range(0,8191)) - 4096, 16384 + int'($urandom_range(0,4300)),
           int'($urandom_range(0,65535)), 2'b11, "");

    // R5: full-scale corners and random wide values
    step(1'b1, -32768, 1'b1, 32767, -32768, 32767, 2'b11, "R5");
    step(1'b1, -32768, 1'b1, 32767, 32767, -32768, 2'b11, "R5");
    step(1'b1, 30000, 1'b1, -30000, 16'h6000, 16'h6000, 2'b11, "R5");
    for (int i = 0; i < 80; i++)
      step(1'b1, rnd16(), 1'b1, rnd16(), rnd16(), rnd16(), 2'b11, "");

    // R2: one enable bit at a time, half gain so the effect is visible
    for (int i = 0; i < 20; i++)
      step(1'b1, rnd16(), 1'b1, rnd16(), 16'h2000, 16'h2000, 2'b01, "R2");
    for (int i = 0; i < 20; i++)
      step(1'b1, rnd16(), 1'b1, rnd16(), 16'h2000, 16'h2000, 2'b10, "R2");

    // R8: settings change on every cycle, samples only on alternate cycles
    for (int i = 0; i < 60; i++)
      step(i % 2 == 0, rnd16(), i % 2 == 0, rnd16(), rnd16(), rnd16(),
           2'($urandom_range(0,3)), "R8");

    // R10: independent strobe patterns
    for (int i = 0; i < 60; i++)
      step(i % 3 == 0, rnd16(), i % 5 != 0, rnd16(), rnd16(), rnd16(), 2'b11, "R10");

    // R1: reset in the middle of traffic
    step(1'b1, 1234, 1'b1, -4321, 16'h4000, 16'h4000, 2'b11, "R1");
    @(negedge clk);
    rst_n = 1'b0; va = 1'b0; vb = 1'b0;
    #1;
    check_reset_outputs();
    clear_model();
    @(negedge clk);
    rst_n = 1'b1;

    // drain
    for (int i = 0; i < 4; i++) step(1'b0, 0, 1'b0, 0, 0, 0, 2'b00, "");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule